// File: doc/BRIEF.md
# Reversal-Shared Shift and Permute Unit

This combinational unit produces shift and bit-permutation results for a 32-bit datapath from one right-shifting structure. Left shifts reverse the operand, pass it through the right shifter and reverse the result back. The same reversal hardware also produces full bit reversal, byte-order swap and a per-byte OR-combine.

The shifter is one bit wider than the operand. The extra top bit is a fill bit that is shifted into vacated positions. It is zero for the logical shifts, the sign bit for arithmetic right shift, and one for the two ones-filling shifts. The caller presents an operand, a 5-bit shift amount and a 3-bit operation code, and reads the result in the same cycle.

Top module: `revshift_unit`

## Requirements
- R1: Operation code 0 (shift left) returns the operand shifted toward the MSB by `amt_i` positions, with zeros entering at bit 0.
- R2: Operation code 1 (logical shift right) returns the operand shifted toward the LSB by `amt_i` positions, with zeros entering at bit 31.
- R3: Operation code 2 (arithmetic shift right) shifts toward the LSB, and every vacated upper bit takes the value of operand bit 31.
- R4: Operation code 3 (shift left ones) shifts toward the MSB, and ones enter at the vacated low bits.
- R5: Operation code 4 (shift right ones) shifts toward the LSB, and ones enter at the vacated high bits.
- R6: For each of the five shift codes (0 to 4), a shift amount of zero returns the operand unchanged.
- R7: Operation code 5 returns the operand with its bit order reversed: result bit i equals operand bit 31-i.
- R8: Operation code 6 reverses the order of the four bytes and keeps the bit order inside each byte. Result byte i equals operand byte 3-i.
- R9: Operation code 7 returns, for each byte, 0xFF if any bit of the same operand byte is set, and 0x00 otherwise.
- R10: For operation codes 5, 6 and 7 the value on `amt_i` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Data word to shift or permute |
| amt_i | input | 5 | Shift distance, 0 to 31 |
| op_i | input | 3 | Operation code, encodings as in R1 to R9 |
| result_o | output | 32 | Result of the selected operation |

## Verification
The embedded checks assume that `op_i`, `amt_i` and `operand_i` are settled, known values whenever they are evaluated. All eight codes of `op_i` are legal, so the checks exclude no value of it. The bench changes inputs only on the falling clock edge and reads the result one half-period later, so every check sees settled inputs. The permutation checks also drive nonzero shift amounts, to show that the shift distance cannot leak into those results.

// File: rtl/revshift_pkg.sv
package revshift_pkg;

  typedef enum logic [2:0] {
    OP_SLL   = 3'd0,
    OP_SRL   = 3'd1,
    OP_SRA   = 3'd2,
    OP_SLO   = 3'd3,
    OP_SRO   = 3'd4,
    OP_REV   = 3'd5,
    OP_BSWAP = 3'd6,
    OP_ORCB  = 3'd7
  } rs_op_e;

  // Operations that run on the reversed operand.
  function automatic logic op_is_left(input rs_op_e op);
    return (op == OP_SLL) || (op == OP_SLO);
  endfunction

  // Operations that only permute and do not shift.
  function automatic logic op_is_perm(input rs_op_e op);
    return (op == OP_REV) || (op == OP_BSWAP) || (op == OP_ORCB);
  endfunction

  // Value shifted into the vacated positions.
  function automatic logic op_fill(input rs_op_e op, input logic msb);
    case (op)
      OP_SRA:         return msb;
      OP_SLO, OP_SRO: return 1'b1;
      default:        return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/revshift_bitrev.sv
module revshift_bitrev #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = din[W-1-i];
  end
endmodule

// File: rtl/revshift_rshift.sv
module revshift_rshift #(
  parameter int W  = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic          fill,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);
  // Logarithmic right shifter, one bit wider than the data so the fill bit travels with it.
  logic [W:0] stg [AW+1];

  assign stg[0] = {fill, din};

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int STEP = 2 ** k;
    assign stg[k+1] = amt[k] ? {{STEP{fill}}, stg[k][W:STEP]} : stg[k];
  end

  assign dout = stg[AW][W-1:0];
endmodule

// File: rtl/revshift_bytes.sv
module revshift_bytes #(
  parameter int W  = 32,
  localparam int NB = W / 8
) (
  input  logic [W-1:0] rev_word,   // full bit reversal of the operand
  output logic [W-1:0] swap_word,
  output logic [W-1:0] orc_word
);
  // Byte b of rev_word holds operand byte NB-1-b with its bits reversed.
  for (genvar b = 0; b < NB; b++) begin : g_byte
    for (genvar j = 0; j < 8; j++) begin : g_bit
      assign swap_word[8*b + j] = rev_word[8*b + 7 - j];
    end
    assign orc_word[8*b +: 8] = {8{|rev_word[8*(NB-1-b) +: 8]}};
  end
endmodule

// File: rtl/revshift_unit.sv
module revshift_unit
  import revshift_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W),
  localparam int NBYTE = DATA_W / 8
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic [2:0]        op_i,
  output logic [DATA_W-1:0] result_o
);
  rs_op_e op;
  assign op = rs_op_e'(op_i);

  // Named internal events.
  logic              go_left;
  logic              go_perm;
  logic              fill_bit;
  logic [AMT_W-1:0]  amt_eff;
  logic [DATA_W-1:0] opnd_rev;
  logic [DATA_W-1:0] sh_in;
  logic [DATA_W-1:0] sh_out;
  logic [DATA_W-1:0] out_rev;
  logic [DATA_W-1:0] swap_word;
  logic [DATA_W-1:0] orc_word;

  assign go_left  = op_is_left(op);
  assign go_perm  = op_is_perm(op);
  assign fill_bit = op_fill(op, operand_i[DATA_W-1]);
  assign amt_eff  = go_perm ? '0 : amt_i;

  revshift_bitrev #(.W(DATA_W)) u_rev_in (
    .din  (operand_i),
    .dout (opnd_rev)
  );

  assign sh_in = go_left ? opnd_rev : operand_i;

  revshift_rshift #(.W(DATA_W)) u_shift (
    .din  (sh_in),
    .fill (fill_bit),
    .amt  (amt_eff),
    .dout (sh_out)
  );

  // The output reverser restores left-shift order and also gives the plain bit reversal.
  revshift_bitrev #(.W(DATA_W)) u_rev_out (
    .din  (sh_out),
    .dout (out_rev)
  );

  revshift_bytes #(.W(DATA_W)) u_bytes (
    .rev_word  (out_rev),
    .swap_word (swap_word),
    .orc_word  (orc_word)
  );

  always_comb begin
    unique case (op)
      OP_SLL, OP_SLO, OP_REV: result_o = out_rev;
      OP_SRL, OP_SRA, OP_SRO: result_o = sh_out;
      OP_BSWAP:               result_o = swap_word;
      OP_ORCB:                result_o = orc_word;
      default:                result_o = sh_out;
    endcase
  end

  // Embedded checks
  always_comb begin
    // R6: a zero distance leaves the operand unchanged for every shift code
    if (!go_perm && amt_i == '0)
      p_zero_amt_identity_r6: assert (result_o == operand_i);
    // R3: the top bit after an arithmetic right shift equals the operand sign bit
    if (op == OP_SRA)
      p_sra_sign_kept_r3: assert (result_o[DATA_W-1] == operand_i[DATA_W-1]);
    // R4: a nonzero left-ones shift always sets bit 0
    if (op == OP_SLO && amt_i != '0)
      p_slo_low_one_r4: assert (result_o[0] == 1'b1);
    // R5: a nonzero right-ones shift always sets the top bit
    if (op == OP_SRO && amt_i != '0)
      p_sro_high_one_r5: assert (result_o[DATA_W-1] == 1'b1);
    // R2: a nonzero logical right shift always clears the top bit
    if (op == OP_SRL && amt_i != '0)
      p_srl_high_zero_r2: assert (result_o[DATA_W-1] == 1'b0);
    // R7: the operand reversed by the input reverser matches the reversal result
    if (op == OP_REV)
      p_rev_matches_input_r7: assert (result_o == opnd_rev);
    // R10: permutation codes never see a nonzero shift distance
    if (go_perm)
      p_perm_no_shift_r10: assert (sh_out == operand_i);
  end

  for (genvar b = 0; b < NBYTE; b++) begin : g_orc_chk
    always_comb begin
      // R9: each byte of the OR-combine result is all zeros or all ones
      if (op == OP_ORCB)
        p_orcb_byte_uniform_r9: assert (result_o[8*b +: 8] == 8'h00 ||
                                        result_o[8*b +: 8] == 8'hFF);
    end
  end

endmodule

// File: tb/revshift_unit_bench.sv
module revshift_unit_bench;

  logic        clk = 1'b0;
  logic [31:0] operand_i;
  logic [4:0]  amt_i;
  logic [2:0]  op_i;
  logic [31:0] result_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  revshift_unit u_revshift_unit (
    .operand_i (operand_i),
    .amt_i     (amt_i),
    .op_i      (op_i),
    .result_o  (result_o)
  );

  // Reference models, written independently of the RTL
  function automatic logic [31:0] m_rev(input logic [31:0] a);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) r[31-i] = a[i];
    return r;
  endfunction

  function automatic logic [31:0] m_orc(input logic [31:0] a);
    logic [31:0] r = '0;
    for (int b = 0; b < 4; b++) if (a[8*b +: 8] != 8'h00) r[8*b +: 8] = 8'hFF;
    return r;
  endfunction

  function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] a,
                                        input logic [4:0] s);
    case (op)
      3'd0: return a << s;
      3'd1: return a >> s;
      3'd2: return $unsigned($signed(a) >>> s);
      3'd3: return ~((~a) << s);
      3'd4: return ~((~a) >> s);
      3'd5: return m_rev(a);
      3'd6: return {a[7:0], a[15:8], a[23:16], a[31:24]};
      default: return m_orc(a);
    endcase
  endfunction

  task automatic apply_check(input string req, input logic [2:0] op,
                             input logic [31:0] a, input logic [4:0] s);
    logic [31:0] exp;
    @(negedge clk);
    op_i = op; operand_i = a; amt_i = s;
    @(posedge clk);
    exp = model(op, a, s);
    n_checks++;
    if (result_o !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h s=%0d actual=%h expected=%h",
               req, op, a, s, result_o, exp);
    end
  endtask

  task automatic t_idle;       // quiet inputs give a zero result
    apply_check("R1", 3'd0, 32'h0, 5'd0);
  endtask

  task automatic t_sll;        // R1
    apply_check("R1", 3'd0, 32'h8000_0001, 5'd1);
    apply_check("R1", 3'd0, 32'hDEAD_BEEF, 5'd31);
    apply_check("R1", 3'd0, 32'h1234_5678, 5'd12);
  endtask

  task automatic t_srl;        // R2
    apply_check("R2", 3'd1, 32'h8000_0000, 5'd31);
    apply_check("R2", 3'd1, 32'hF0F0_1234, 5'd7);
  endtask

  task automatic t_sra;        // R3
    apply_check("R3", 3'd2, 32'h8000_0000, 5'd31);
    apply_check("R3", 3'd2, 32'h7FFF_0000, 5'd16);
    apply_check("R3", 3'd2, 32'hC001_0010, 5'd3);
  endtask

  task automatic t_slo;        // R4
    apply_check("R4", 3'd3, 32'h0000_0000, 5'd5);
    apply_check("R4", 3'd3, 32'h0F00_0000, 5'd31);
  endtask

  task automatic t_sro;        // R5
    apply_check("R5", 3'd4, 32'h0000_0000, 5'd1);
    apply_check("R5", 3'd4, 32'h1234_5678, 5'd20);
  endtask

  task automatic t_zero_amt;   // R6
    for (int op = 0; op < 5; op++)
      apply_check("R6", 3'(op), 32'hA5C3_0F96, 5'd0);
  endtask

  task automatic t_rev;        // R7
    apply_check("R7", 3'd5, 32'h0000_0001, 5'd0);
    apply_check("R7", 3'd5, 32'h1234_5678, 5'd0);
  endtask

  task automatic t_bswap;      // R8
    apply_check("R8", 3'd6, 32'h1122_3344, 5'd0);
    apply_check("R8", 3'd6, 32'h8001_C003, 5'd0);
  endtask

  task automatic t_orcb;       // R9
    apply_check("R9", 3'd7, 32'h0080_0100, 5'd0);
    apply_check("R9", 3'd7, 32'h0000_0000, 5'd0);
    apply_check("R9", 3'd7, 32'h0102_0408, 5'd0);
  endtask

  task automatic t_perm_amt;   // R10: a nonzero distance must not change the permutation results
    apply_check("R10", 3'd5, 32'h1234_5678, 5'd9);
    apply_check("R10", 3'd6, 32'h1234_5678, 5'd31);
    apply_check("R10", 3'd7, 32'h0010_0000, 5'd17);
  endtask

  initial begin
    op_i = 3'd0; operand_i = '0; amt_i = '0;
    repeat (2) @(posedge clk);
    t_idle();
    t_sll();
    t_srl();
    t_sra();
    t_slo();
    t_sro();
    t_zero_amt();
    t_rev();
    t_bswap();
    t_orcb();
    t_perm_amt();
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule